// File: doc/BRIEF.md
# Multi-Mode Page Table Walker

This block turns a 32-bit linear address into a physical address. It does this by reading paging structures held in memory, one entry at a time. Two mode inputs pick the layout at run time. The first selects either the classic 4-byte-entry format or the extended 8-byte-entry format, which produces wider physical addresses. The second allows large pages, which end the walk at the directory level. A root-pointer input gives the physical address of the top-level table. In classic mode that table is the page directory. In extended mode it is the four-entry pointer table.

A walk begins when `startReq` is seen while `ready` is high. The walker then drives one read at a time on a simple memory port. Each read stays valid until the memory answers. The walker decodes every returned entry and either moves down a level, stops with a translation, or stops with a fault. It ends by pulsing `done` for one cycle, with `physAddr`, `fault` and `faultLevel` valid in that cycle.

Top module: `pageWalker`

## Requirements
- R1: After reset, `ready` is 1 and `memReqValid`, `done` and `fault` are 0.
- R2: A start is taken only while `ready` is 1. The walker then leaves idle in the next cycle with a read pending. A `startReq` during a walk, and any change to `linAddr`, `baseAddr`, `paeMode` or `largeMode` during a walk, has no effect on that walk's reads or result.
- R3: Classic 4 KB mode (`paeMode`=0, no large leaf) reads two entries.
  - The directory entry is read at `baseAddr + 4*linAddr[31:22]`.
  - The table entry is read at `{entry[31:12],12'h000} + 4*linAddr[21:12]`.
  - The result is `{4'h0, tableEntry[31:12], linAddr[11:0]}`.
  - Bits 63:32 of every response are ignored.
- R4: Classic large pages (`paeMode`=0, `largeMode`=1, directory entry bit 7 set) need one read. The result is `{4'h0, dirEntry[31:22], linAddr[21:0]}`.
- R5: Extended 4 KB mode (`paeMode`=1) reads three 8-byte entries.
  - The pointer entry is read at `baseAddr + 8*linAddr[31:30]`.
  - The directory entry is read at `{ptr[35:12],12'h000} + 8*linAddr[29:21]`.
  - The table entry is read at `{dir[35:12],12'h000} + 8*linAddr[20:12]`.
  - The result is `{tableEntry[35:12], linAddr[11:0]}`.
- R6: Extended large pages (`paeMode`=1, `largeMode`=1, directory entry bit 7 set) need two reads. The result is `{dirEntry[35:21], linAddr[20:0]}`.
- R7: Bit 7 of a directory entry has no effect when `largeMode` is 0. Bit 7 of a pointer-table entry or a page-table entry never has an effect.
- R8: An entry with bit 0 clear stops the walk with no further reads. The walker then sets `fault`=1 and `physAddr`=0. `faultLevel` gives where the walk stopped: 0 for the pointer table, 1 for the directory, 2 for the page table.
- R9: `done` is high for exactly one cycle. That cycle immediately follows the cycle in which the last response was taken, and `ready` is 1 in the cycle after `done`.
- R10: Once `memReqValid` is raised, it stays high with `memReqAddr` unchanged until a cycle with `memRespValid`. Only one read is outstanding at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| startReq | input | 1 | Begin a walk (taken when `ready`) |
| linAddr | input | 32 | Linear address to translate |
| baseAddr | input | PA_W | Physical address of the top-level table |
| paeMode | input | 1 | 1 selects the extended 8-byte-entry format |
| largeMode | input | 1 | 1 lets directory bit 7 end the walk as a large page |
| ready | output | 1 | Walker idle, able to take a start |
| memReqValid | output | 1 | Read request pending |
| memReqAddr | output | PA_W | Byte address of the entry being read |
| memRespValid | input | 1 | Read data valid this cycle |
| memRespData | input | 64 | Entry data (classic entries in bits 31:0) |
| done | output | 1 | One-cycle completion pulse |
| physAddr | output | PA_W | Translated address, valid with `done` |
| fault | output | 1 | Walk ended on a non-present entry |
| faultLevel | output | 2 | Level of the non-present entry |

## Verification
The hardest case to reach from the ports is a walk that must stop or go on at exactly the right level. Examples are a non-present entry deep in a three-level walk, or bit 7 set at a level where it must be ignored. These cases depend on table contents at addresses the walker computes itself. To reach them, the bench builds each walk's structures in a sparse memory model. It places every entry at the address the requirements predict and clears the present bit, or sets bit 7, at a chosen level. It also counts how many reads the memory model served, which shows whether the walk stopped early. Stray starts and changed mode inputs during a walk, along with random memory latency, check that the walker captures its inputs only once.

// File: rtl/walkPkg.sv
package walkPkg;

  localparam logic [1:0] LVL_PDPT = 2'd0;
  localparam logic [1:0] LVL_DIR  = 2'd1;
  localparam logic [1:0] LVL_TBL  = 2'd2;

  // strobes from control to datapath
  typedef struct packed {
    logic load;     // capture request, start at top level
    logic descend;  // follow pointer to next level
    logic finish;   // record translated address
    logic fail;     // record fault at current level
  } walkStrobe_t;

  // decoded view of the current response
  typedef struct packed {
    logic present;
    logic leaf;
  } walkStatus_t;

endpackage

// File: rtl/walkCtrl.sv
module walkCtrl
  import walkPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startReq,
  input  logic        memRespValid,
  input  walkStatus_t status,
  output walkStrobe_t strobe,
  output logic        ready,
  output logic        memReqValid,
  output logic        done
);

  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_DONE} walkState_e;

  walkState_e stateQ, stateD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    stateD = stateQ;
    strobe = '0;
    unique case (stateQ)
      ST_IDLE: begin
        // R2: starts only taken here
        if (startReq) begin
          strobe.load = 1'b1;
          stateD      = ST_FETCH;
        end
      end
      ST_FETCH: begin
        if (memRespValid) begin
          if (!status.present) begin
            strobe.fail = 1'b1;
            stateD      = ST_DONE;
          end else if (status.leaf) begin
            strobe.finish = 1'b1;
            stateD        = ST_DONE;
          end else begin
            strobe.descend = 1'b1;
          end
        end
      end
      ST_DONE: stateD = ST_IDLE;
      default: stateD = ST_IDLE;
    endcase
  end

  assign ready       = (stateQ == ST_IDLE);
  assign memReqValid = (stateQ == ST_FETCH);
  assign done        = (stateQ == ST_DONE);

endmodule

// File: rtl/walkPath.sv
module walkPath
  import walkPkg::*;
#(
  parameter int PA_W   = 36,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  walkStrobe_t       strobe,
  input  logic [31:0]       linAddr,
  input  logic [PA_W-1:0]   baseAddr,
  input  logic              paeMode,
  input  logic              largeMode,
  input  logic [DATA_W-1:0] memRespData,
  output walkStatus_t       status,
  output logic [PA_W-1:0]   memReqAddr,
  output logic [PA_W-1:0]   physAddr,
  output logic              fault,
  output logic [1:0]        faultLevel
);

  localparam int OFS_W   = 12;  // widest entry offset within a table
  localparam int WIDE_HI = 35;  // top frame bit of an extended entry

  logic [31:0]     linQ;
  logic            paeQ, largeQ;
  logic [PA_W-1:0] tblBaseQ;
  logic [1:0]      levelQ;
  logic [PA_W-1:0] physQ;
  logic            faultQ;
  logic [1:0]      faultLvlQ;

  logic [OFS_W-1:0]  entOfs;
  logic [DATA_W-1:0] entry;
  logic              bigPage;
  logic [PA_W-1:0]   nextBase;
  logic [PA_W-1:0]   leafAddr;
  logic              unusedEntryBits;

  // entry offset from linear-address field of current level (R3, R5)
  always_comb begin
    if (paeQ) begin
      unique case (levelQ)
        LVL_PDPT: entOfs = {7'd0, linQ[31:30], 3'b000};
        LVL_DIR:  entOfs = {linQ[29:21], 3'b000};
        default:  entOfs = {linQ[20:12], 3'b000};
      endcase
    end else begin
      if (levelQ == LVL_DIR) entOfs = {linQ[31:22], 2'b00};
      else                   entOfs = {linQ[21:12], 2'b00};
    end
  end

  assign memReqAddr = tblBaseQ + PA_W'(entOfs);

  // classic entries are 4 bytes: upper response half ignored (R3)
  assign entry = paeQ ? memRespData : {{(DATA_W-32){1'b0}}, memRespData[31:0]};

  // large leaf only at directory level with large mode on (R4, R6, R7)
  assign bigPage        = largeQ && (levelQ == LVL_DIR) && entry[7];
  assign status.present = entry[0];
  assign status.leaf    = (levelQ == LVL_TBL) || bigPage;

  always_comb begin
    if (paeQ) nextBase = PA_W'({entry[WIDE_HI:12], 12'h000});
    else      nextBase = PA_W'({entry[31:12], 12'h000});
  end

  always_comb begin
    unique case ({paeQ, bigPage})
      2'b00:   leafAddr = PA_W'({entry[31:12], linQ[11:0]});
      2'b01:   leafAddr = PA_W'({entry[31:22], linQ[21:0]});
      2'b10:   leafAddr = PA_W'({entry[WIDE_HI:12], linQ[11:0]});
      default: leafAddr = PA_W'({entry[WIDE_HI:21], linQ[20:0]});
    endcase
  end

  assign unusedEntryBits = ^{entry[DATA_W-1:WIDE_HI+1], entry[11:8], entry[6:1]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      linQ      <= '0;
      paeQ      <= 1'b0;
      largeQ    <= 1'b0;
      tblBaseQ  <= '0;
      levelQ    <= LVL_DIR;
      physQ     <= '0;
      faultQ    <= 1'b0;
      faultLvlQ <= '0;
    end else begin
      if (strobe.load) begin
        linQ     <= linAddr;
        paeQ     <= paeMode;
        largeQ   <= largeMode;
        tblBaseQ <= baseAddr;
        levelQ   <= paeMode ? LVL_PDPT : LVL_DIR;
      end
      if (strobe.descend) begin
        tblBaseQ <= nextBase;
        levelQ   <= levelQ + 2'd1;
      end
      if (strobe.finish) begin
        physQ     <= leafAddr;
        faultQ    <= 1'b0;
        faultLvlQ <= '0;
      end
      if (strobe.fail) begin  // R8
        physQ     <= '0;
        faultQ    <= 1'b1;
        faultLvlQ <= levelQ;
      end
    end
  end

  assign physAddr   = physQ;
  assign fault      = faultQ;
  assign faultLevel = faultLvlQ;

endmodule

// File: rtl/pageWalker.sv
module pageWalker
  import walkPkg::*;
#(
  parameter int PA_W   = 36,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic [31:0]       linAddr,
  input  logic [PA_W-1:0]   baseAddr,
  input  logic              paeMode,
  input  logic              largeMode,
  output logic              ready,
  output logic              memReqValid,
  output logic [PA_W-1:0]   memReqAddr,
  input  logic              memRespValid,
  input  logic [DATA_W-1:0] memRespData,
  output logic              done,
  output logic [PA_W-1:0]   physAddr,
  output logic              fault,
  output logic [1:0]        faultLevel
);

  walkStrobe_t strobe;
  walkStatus_t status;

  walkCtrl ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .startReq     (startReq),
    .memRespValid (memRespValid),
    .status       (status),
    .strobe       (strobe),
    .ready        (ready),
    .memReqValid  (memReqValid),
    .done         (done)
  );

  walkPath #(.PA_W(PA_W), .DATA_W(DATA_W)) path (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .linAddr     (linAddr),
    .baseAddr    (baseAddr),
    .paeMode     (paeMode),
    .largeMode   (largeMode),
    .memRespData (memRespData),
    .status      (status),
    .memReqAddr  (memReqAddr),
    .physAddr    (physAddr),
    .fault       (fault),
    .faultLevel  (faultLevel)
  );

endmodule

// File: rtl/walkCheck.sv
module walkCheck #(
  parameter int PA_W = 36
) (
  input logic            clk,
  input logic            rstN,
  input logic            startReq,
  input logic            ready,
  input logic            memReqValid,
  input logic [PA_W-1:0] memReqAddr,
  input logic            memRespValid,
  input logic            done,
  input logic [PA_W-1:0] physAddr,
  input logic            fault,
  input logic [1:0]      faultLevel
);

  assert_start_taken_R2: assert property (@(posedge clk) disable iff (!rstN)
    ready && startReq |=> !ready && memReqValid);

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    ready && !startReq |=> ready && !memReqValid);

  assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memRespValid |=> memReqValid && $stable(memReqAddr));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done && ready);

  assert_done_cause_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(memReqValid && memRespValid));

  assert_fault_shape_R8: assert property (@(posedge clk) disable iff (!rstN)
    done && fault |-> physAddr == '0 && faultLevel != 2'd3);

endmodule

bind pageWalker walkCheck #(.PA_W(PA_W)) walkCheckInst (
  .clk          (clk),
  .rstN         (rstN),
  .startReq     (startReq),
  .ready        (ready),
  .memReqValid  (memReqValid),
  .memReqAddr   (memReqAddr),
  .memRespValid (memRespValid),
  .done         (done),
  .physAddr     (physAddr),
  .fault        (fault),
  .faultLevel   (faultLevel)
);

// File: tb/pageWalker_test.sv
`timescale 1ns/1ps
module pageWalker_test;

  localparam int PA_W = 36;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            startReq = 1'b0;
  logic [31:0]     linAddr = '0;
  logic [PA_W-1:0] baseAddr = '0;
  logic            paeMode = 1'b0;
  logic            largeMode = 1'b0;
  logic            ready, memReqValid, done, fault;
  logic [PA_W-1:0] memReqAddr, physAddr;
  logic            memRespValid = 1'b0;
  logic [63:0]     memRespData = '0;
  logic [1:0]      faultLevel;

  int checks = 0;
  int errors = 0;
  int reads = 0;
  int waitCnt = 0;
  int cycleCnt = 0;
  int lastRespCycle = 0;
  logic [63:0] memModel [logic [35:0]];

  always #2 clk = ~clk;  // 250 MHz

  pageWalker #(.PA_W(PA_W)) uut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .linAddr(linAddr),
    .baseAddr(baseAddr), .paeMode(paeMode), .largeMode(largeMode),
    .ready(ready), .memReqValid(memReqValid), .memReqAddr(memReqAddr),
    .memRespValid(memRespValid), .memRespData(memRespData), .done(done),
    .physAddr(physAddr), .fault(fault), .faultLevel(faultLevel)
  );

  initial forever @(posedge clk) cycleCnt++;

  // memory model: answers at a negedge after 0..2 idle negedges
  initial forever begin
    @(negedge clk);
    if (memRespValid) begin
      memRespValid = 1'b0;
    end else if (memReqValid) begin
      if (waitCnt == 0) begin
        memRespData   = memModel.exists(memReqAddr) ? memModel[memReqAddr] : 64'd0;
        memRespValid  = 1'b1;
        reads++;
        lastRespCycle = cycleCnt;
        waitCnt       = $urandom % 3;
      end else begin
        waitCnt--;
      end
    end
  end

  task automatic chk(input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [35:0] entryOffset(input bit pae, input int lv,
                                              input logic [31:0] lin);
    if (pae) begin
      if (lv == 0)      return 36'(lin[31:30]) * 8;
      else if (lv == 1) return 36'(lin[29:21]) * 8;
      else              return 36'(lin[20:12]) * 8;
    end
    if (lv == 1) return 36'(lin[31:22]) * 4;
    return 36'(lin[21:12]) * 4;
  endfunction

  // kind: 0 classic 4K, 1 classic large, 2 extended 4K, 3 extended large
  task automatic doCase(input int kind, input int failLvl, input bit junk,
                        input bit largeIn, input bit stray, input string tag);
    bit pae = (kind >= 2);
    bit big = (kind == 1) || (kind == 3);
    logic [31:0] lin = $urandom;
    logic [35:0] base, cur, addr, expPhys;
    logic [63:0] ent;
    bit expFault = 0;
    int expLvl = 0;
    int expReads = 0;
    int t = 0;
    if (big) largeIn = 1'b1;
    base = pae ? {4'h0, $urandom & 32'hFFFF_FFE0} : {4'h0, $urandom & 32'hFFFF_F000};
    memModel.delete();
    cur = base;
    expPhys = '0;
    for (int lv = (pae ? 0 : 1); lv <= 2; lv++) begin
      ent = {$urandom, $urandom};
      addr = cur + entryOffset(pae, lv, lin);
      expReads++;
      ent[0] = (lv == failLvl) ? 1'b0 : 1'b1;
      if (lv == 1) ent[7] = big ? 1'b1 : (largeIn ? 1'b0 : junk);
      else         ent[7] = junk;
      memModel[addr] = ent;
      if (lv == failLvl) begin
        expFault = 1;
        expLvl = lv;
        break;
      end
      if (lv == 2 || (lv == 1 && big)) begin
        unique case (kind)
          0: expPhys = {4'h0, ent[31:12], lin[11:0]};
          1: expPhys = {4'h0, ent[31:22], lin[21:0]};
          2: expPhys = {ent[35:12], lin[11:0]};
          default: expPhys = {ent[35:21], lin[20:0]};
        endcase
        break;
      end
      cur = pae ? {ent[35:12], 12'h000} : {4'h0, ent[31:12], 12'h000};
    end

    @(negedge clk);
    while (!ready) @(negedge clk);
    reads = 0;
    linAddr = lin; baseAddr = base; paeMode = pae; largeMode = largeIn;
    startReq = 1'b1;
    @(negedge clk);
    startReq = stray;  // R2: stray start and changed inputs mid-walk
    if (stray) begin
      linAddr = ~lin; baseAddr = base ^ 36'h0_1234_5000;
      paeMode = ~pae; largeMode = ~largeIn;
    end
    @(negedge clk);
    startReq = 1'b0;
    while (!done && t < 400) begin
      @(negedge clk);
      t++;
    end
    chk("R9", "done seen", 64'(done), 64'd1);
    chk(tag, "fault", 64'(fault), 64'(expFault));
    chk(tag, "physAddr", 64'(physAddr), 64'(expPhys));
    if (expFault) chk("R8", "faultLevel", 64'(faultLevel), 64'(expLvl));
    chk(tag, "read count", 64'(reads), 64'(expReads));
    chk("R9", "done timing", 64'(cycleCnt), 64'(lastRespCycle + 1));
    @(negedge clk);
    chk("R9", "done width", 64'(done), 64'd0);
    chk("R9", "ready after done", 64'(ready), 64'd1);
    chk("R10", "no read after done", 64'(reads), 64'(expReads));
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog R9 actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    string kindTag [4] = '{"R3", "R4", "R5", "R6"};
    void'($urandom(32'd20250611));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", "ready", 64'(ready), 64'd1);
    chk("R1", "memReqValid", 64'(memReqValid), 64'd0);
    chk("R1", "done", 64'(done), 64'd0);
    chk("R1", "fault", 64'(fault), 64'd0);

    // main function per layout
    for (int k = 0; k < 4; k++) doCase(k, -1, 1'b0, 1'b0, 1'b0, kindTag[k]);
    // R3 with large mode on but directory bit 7 clear
    doCase(0, -1, 1'b0, 1'b1, 1'b0, "R3");
    // R7: bit 7 where it must be ignored
    doCase(0, -1, 1'b1, 1'b0, 1'b0, "R7");
    doCase(2, -1, 1'b1, 1'b0, 1'b0, "R7");
    doCase(2, -1, 1'b1, 1'b1, 1'b0, "R7");
    doCase(3, -1, 1'b1, 1'b1, 1'b0, "R7");
    // R8: non-present at each level
    doCase(2, 0, 1'b0, 1'b0, 1'b0, "R8");
    doCase(2, 1, 1'b0, 1'b0, 1'b0, "R8");
    doCase(2, 2, 1'b0, 1'b0, 1'b0, "R8");
    doCase(0, 1, 1'b0, 1'b0, 1'b0, "R8");
    doCase(0, 2, 1'b0, 1'b0, 1'b0, "R8");
    doCase(1, 1, 1'b0, 1'b1, 1'b0, "R8");
    doCase(3, 0, 1'b0, 1'b1, 1'b0, "R8");
    doCase(3, 1, 1'b0, 1'b1, 1'b0, "R8");
    // R2: stray starts and changed inputs during walks
    for (int k = 0; k < 4; k++) doCase(k, -1, 1'b0, 1'b0, 1'b1, "R2");

    // constrained random mix
    for (int n = 0; n < 300; n++) begin
      int kind = $urandom % 4;
      bit pae = (kind >= 2);
      bit big = (kind == 1) || (kind == 3);
      int lo = pae ? 0 : 1;
      int hi = big ? 1 : 2;
      int fl = -1;
      if ($urandom % 5 == 0) fl = lo + ($urandom % (hi - lo + 1));
      doCase(kind, fl, 1'($urandom), 1'($urandom), 1'($urandom),
             (fl >= 0) ? "R8" : kindTag[kind]);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule